// File: doc/BRIEF.md
# Multi-Channel Comparator Sampling Sequencer

This block is the digital control around a bank of comparator channels. Each channel gives a raw one-bit compare result as an ordinary synchronous input. Once the power-up input has been high for a settle period, the block visits the enabled channels one per clock, starting at channel 0, and registers each result into a per-channel output. A one-cycle ready pulse marks the end of each complete pass.

Two selects shape the behaviour. The trigger select chooses between continuous passes for as long as power-up stays high, and a single pass after each rising edge of power-up. The output select chooses between showing each result in the cycle its channel is sampled, and holding all results in a staging register so that they appear together when the pass completes. A separate active-low channel-clear input forces low every channel whose clear-enable bit is set, asynchronously and for as long as it is held low.

Top module: `cmp_sample_seq`

## Requirements
- R1: No channel is sampled until power-up has been high for SETTLE_CYC consecutive clock edges. With power-up first seen high at edge E0, channel 0 is captured at edge E(SETTLE_CYC+1). Before that, cmp_o and ready_o stay 0 after reset.
- R2: The channel count chan_cnt_i enables channels 0 to count-1. A count of 0 acts as 1 and a count above N_CH acts as N_CH. Outputs of channels at or above the count keep their value during a pass.
- R3: In staggered mode (simul_mode_i=0), channel i's output takes its raw input at edge i+1 after the pass-start edge, so consecutive channels change one clock apart.
- R4: In simultaneous mode (simul_mode_i=1), no output changes until the edge that samples the last enabled channel. At that edge all enabled outputs update together.
- R5: ready_o is high for exactly one cycle, directly after the edge that samples the last enabled channel of a pass.
- R6: In level mode (edge_mode_i=0), passes repeat for as long as power-up stays high. Each pass takes count+1 cycles, so successive ready pulses are count+1 cycles apart.
- R7: In edge mode (edge_mode_i=1), each rising edge of power-up gives exactly one pass. While power-up stays high afterwards, outputs hold and ready_o stays low.
- R8: In level mode, while power-up is low, cmp_o is 0 without waiting for a clock edge. Any pass in progress is abandoned, with no ready pulse.
- R9: While chan_rst_ni is low, every channel whose chan_rst_en_i bit is 1 reads 0 at once, whatever its input. A channel whose bit is 0 is not affected.
- R10: The count, trigger select and output select are taken only at the pass-start edge. A change during a pass does not alter that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| pwr_up_i | input | 1 | Power-up enable |
| chan_rst_ni | input | 1 | Channel clear, active low, asynchronous |
| chan_cnt_i | input | $clog2(N_CH+1) | Number of enabled channels |
| edge_mode_i | input | 1 | 1: one pass per power-up rise, 0: continuous |
| simul_mode_i | input | 1 | 1: release together, 0: staggered |
| chan_rst_en_i | input | N_CH | Per-channel clear enable |
| cmp_raw_i | input | N_CH | Raw compare results |
| cmp_o | output | N_CH | Registered channel results |
| ready_o | output | 1 | One-cycle pass-complete pulse |

## Verification
A channel clear can be active in the same cycle that its channel is sampled or released. The sequencer then tries to write a 1 into a flop that the clear holds at 0. The bench provokes this by holding chan_rst_ni low, with one or two clear-enable bits set, through a whole pass in both output modes. It then checks, cycle by cycle, that the cleared channels stay 0 while the remaining channels update on their scheduled edges and ready_o still pulses on time. It also checks that the cleared channels remain 0 after the clear is released.

// File: rtl/cmp_seq_pkg.sv
package cmp_seq_pkg;
  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;
  typedef enum logic {OUT_STAGGER = 1'b0, OUT_SIMUL = 1'b1} out_e;
endpackage

// File: rtl/cmp_settle.sv
module cmp_settle #(
  parameter int SETTLE_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_up_i,
  output logic settled_o,
  output logic rise_o
);
  localparam int SW = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;

  logic [SW-1:0] cnt_q;
  logic          pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwr_q <= 1'b0;
    end else begin
      pwr_q <= pwr_up_i;
      if (!pwr_up_i)                     cnt_q <= '0;
      else if (cnt_q != SW'(SETTLE_CYC)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settled_o = pwr_up_i && (cnt_q == SW'(SETTLE_CYC));
  assign rise_o    = pwr_up_i && !pwr_q;

  // R1: a low power-up restarts the settle window
  a_r1_settle_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> !settled_o);
endmodule

// File: rtl/cmp_pass_ctrl.sv
module cmp_pass_ctrl
  import cmp_seq_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int CNT_W = $clog2(N_CH + 1),
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_up_i,
  input  logic             settled_i,
  input  logic             rise_i,
  input  logic             edge_mode_i,
  input  logic             simul_mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             sample_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic             start_o,
  output logic             simul_o,
  output logic [N_CH-1:0]  mask_o,
  output logic             blank_o,
  output logic             ready_o
);
  logic             busy_q, armed_q, ready_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] num_q, cnt_eff;
  trig_e            trig_q;
  out_e             omode_q;
  logic             go, start, abort, last;

  always_comb begin
    if (cnt_i == '0)                  cnt_eff = CNT_W'(1);
    else if (cnt_i > CNT_W'(N_CH))    cnt_eff = CNT_W'(N_CH);
    else                              cnt_eff = cnt_i;
  end

  assign go    = settled_i && (edge_mode_i ? armed_q : 1'b1);
  assign start = !busy_q && go;
  assign abort = busy_q && (trig_q == TRIG_LEVEL) && !pwr_up_i;
  assign last  = busy_q && !abort && (CNT_W'(idx_q) == num_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      ready_q <= 1'b0;
      idx_q   <= '0;
      num_q   <= CNT_W'(1);
      trig_q  <= TRIG_LEVEL;
      omode_q <= OUT_STAGGER;
    end else begin
      ready_q <= last;
      if (!pwr_up_i)   armed_q <= 1'b0;
      else if (rise_i) armed_q <= 1'b1;
      else if (start)  armed_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        num_q   <= cnt_eff;
        trig_q  <= trig_e'(edge_mode_i);
        omode_q <= out_e'(simul_mode_i);
      end else if (abort || last) begin
        busy_q  <= 1'b0;
      end else if (busy_q) begin
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_mask
    assign mask_o[i] = CNT_W'(i) < num_q;
  end

  assign sample_en_o = busy_q && !abort;
  assign idx_o       = idx_q;
  assign last_o      = last;
  assign start_o     = start;
  assign simul_o     = (omode_q == OUT_SIMUL);
  assign blank_o     = !pwr_up_i && (trig_q == TRIG_LEVEL);
  assign ready_o     = ready_q;

  a_r5_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);
  a_r1_start_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> settled_i);
  a_r2_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (CNT_W'(idx_q) < num_q));
  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last && !abort) |=> ($stable(num_q) && $stable(omode_q) && $stable(trig_q)));
endmodule

// File: rtl/cmp_out_bank.sv
module cmp_out_bank #(
  parameter int N_CH  = 4,
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_rst_ni,
  input  logic [N_CH-1:0]  rst_en_i,
  input  logic [N_CH-1:0]  raw_i,
  input  logic             sample_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             last_i,
  input  logic             start_i,
  input  logic             simul_i,
  input  logic [N_CH-1:0]  mask_i,
  input  logic             blank_i,
  output logic [N_CH-1:0]  out_o
);
  logic [N_CH-1:0] stage_q;

  // staging for simultaneous release, emptied at every pass start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       stage_q <= '0;
    else if (start_i)                  stage_q <= '0;
    else if (sample_en_i && simul_i)   stage_q[idx_i] <= raw_i[idx_i];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic q, ch_rst_n, hit;
    assign ch_rst_n = rst_ni && !(rst_en_i[g] && !chan_rst_ni);
    assign hit      = (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge ch_rst_n) begin
      if (!ch_rst_n)                q <= 1'b0;
      else if (blank_i)             q <= 1'b0;
      else if (sample_en_i) begin
        if (!simul_i) begin
          if (hit) q <= raw_i[g];
        end else if (last_i && mask_i[g]) begin
          q <= hit ? raw_i[g] : stage_q[g];
        end
      end
    end
    assign out_o[g] = q;

    a_r9_chan_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!chan_rst_ni && rst_en_i[g]) |-> !q);
  end

  a_r4_no_early_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && simul_i && !last_i) |=> ((out_o & ~$past(out_o)) == '0));
  a_r3_one_per_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && !simul_i) |=> ($countones(out_o ^ $past(out_o)) <= 1));
  a_r8_blank_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (out_o == '0));
endmodule

// File: rtl/cmp_sample_seq.sv
module cmp_sample_seq #(
  parameter int N_CH       = 4,
  parameter int SETTLE_CYC = 5000,
  parameter int CNT_W      = $clog2(N_CH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_up_i,
  input  logic             chan_rst_ni,
  input  logic [CNT_W-1:0] chan_cnt_i,
  input  logic             edge_mode_i,
  input  logic             simul_mode_i,
  input  logic [N_CH-1:0]  chan_rst_en_i,
  input  logic [N_CH-1:0]  cmp_raw_i,
  output logic [N_CH-1:0]  cmp_o,
  output logic             ready_o
);
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic             settled, rise, sample_en, last, start, simul, blank;
  logic [IDX_W-1:0] idx;
  logic [N_CH-1:0]  mask, bank_q;

  cmp_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i, .rst_ni, .pwr_up_i, .settled_o(settled), .rise_o(rise)
  );

  cmp_pass_ctrl #(.N_CH(N_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_ctrl (
    .clk_i, .rst_ni, .pwr_up_i,
    .settled_i(settled), .rise_i(rise),
    .edge_mode_i, .simul_mode_i, .cnt_i(chan_cnt_i),
    .sample_en_o(sample_en), .idx_o(idx), .last_o(last), .start_o(start),
    .simul_o(simul), .mask_o(mask), .blank_o(blank), .ready_o
  );

  cmp_out_bank #(.N_CH(N_CH), .IDX_W(IDX_W)) i_bank (
    .clk_i, .rst_ni, .chan_rst_ni, .rst_en_i(chan_rst_en_i), .raw_i(cmp_raw_i),
    .sample_en_i(sample_en), .idx_i(idx), .last_i(last), .start_i(start),
    .simul_i(simul), .mask_i(mask), .blank_i(blank), .out_o(bank_q)
  );

  // level mode: low power-up forces outputs low without waiting for an edge
  assign cmp_o = blank ? '0 : bank_q;
endmodule

// File: tb/test_cmp_sample_seq.sv
module test_cmp_sample_seq;
  localparam int N = 4;
  localparam int S = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr = 1'b0, crst_n = 1'b1, edge_m = 1'b0, sim_m = 1'b0;
  logic [2:0] cnt = 3'd1;
  logic [3:0] rst_en = '0, raw = '0, out;
  logic       rdy;
  int         n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  cmp_sample_seq #(.N_CH(N), .SETTLE_CYC(S)) i_cmp_sample_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(pwr), .chan_rst_ni(crst_n),
    .chan_cnt_i(cnt), .edge_mode_i(edge_m), .simul_mode_i(sim_m),
    .chan_rst_en_i(rst_en), .cmp_raw_i(raw), .cmp_o(out), .ready_o(rdy)
  );

  function automatic logic [3:0] msk(int n);
    return 4'((1 << n) - 1);
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_outs();
    @(negedge clk);
    pwr = 1'b0; rst_en = 4'hF; crst_n = 1'b0;
    #1 check("R9 clear", out, 4'h0);
    @(negedge clk);
    crst_n = 1'b1; rst_en = 4'h0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_edge(int k, bit sim, logic [3:0] p, logic [3:0] hold);
    int ke, alt;
    logic [3:0] fin;
    ke  = (k == 0) ? 1 : k;
    alt = (ke == 4) ? 1 : 4;
    clear_outs();
    cnt = 3'(k); edge_m = 1'b1; sim_m = sim; raw = p;
    rst_en = hold; crst_n = (hold == 4'h0);
    pwr = 1'b1;
    fin = p & msk(ke) & ~hold;
    for (int c = 0; c <= S + ke + 4; c++) begin
      int done;
      logic [3:0] exp;
      @(negedge clk);
      done = c - S;
      if (done < 0)  done = 0;
      if (done > ke) done = ke;
      if (sim) exp = (done == ke) ? (p & msk(ke)) : 4'h0;
      else     exp = p & msk(done);
      exp &= ~hold;
      if (c <= S)            check("R1 before settle", out, exp);
      else if (c > S + ke)   check("R7 one shot hold", out, exp);
      else if (k == 0)       check("R2 zero count", out, exp);
      else if (sim)          check("R4 simultaneous", out, exp);
      else                   check("R3 staggered", out, exp);
      check("R5 ready pulse", {3'b0, rdy}, {3'b0, (c == S + ke)});
      if (c == S + 1) begin cnt = 3'(alt); sim_m = !sim; end  // R10
      if (c == S + ke) raw = ~p;
    end
    check("R10 cfg latched", out, fin);
    crst_n = 1'b1;
    #1 check("R9 after release", out, fin);
    @(negedge clk);
    rst_en = 4'h0; crst_n = 1'b0;
    #1 check("R9 disabled no effect", out, fin);
    @(negedge clk);
    crst_n = 1'b1; pwr = 1'b0;
  endtask

  task automatic run_level(int k, bit sim, logic [3:0] p, logic [3:0] q);
    int ke;
    ke = (k == 0) ? 1 : k;
    clear_outs();
    cnt = 3'(k); edge_m = 1'b0; sim_m = sim; raw = p; pwr = 1'b1;
    for (int c = 0; c <= S + 2 * ke + 1; c++) begin
      @(negedge clk);
      check("R6 ready period", {3'b0, rdy},
            {3'b0, (c == S + ke) || (c == S + 2 * ke + 1)});
      if (c == S + ke) begin
        check("R6 first pass", out, p & msk(ke));
        raw = q;
      end
      if (c == S + 2 * ke + 1) check("R6 second pass", out, q & msk(ke));
    end
    pwr = 1'b0;
    #1 check("R8 blank immediate", out, 4'h0);
    for (int c = 0; c < ke + 2; c++) begin
      @(negedge clk);
      check("R8 no ready after abort", {3'b0, rdy}, 4'h0);
      check("R8 outputs low", out, 4'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] pats [3];
    pats[0] = 4'hF; pats[1] = 4'hA; pats[2] = 4'h6;
    #5 check("R1 reset out", out, 4'h0);
    check("R1 reset ready", {3'b0, rdy}, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k <= N; k++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 3; i++)
          run_edge(k, s[0], pats[i], 4'h0);
    run_edge(4, 1'b0, 4'hF, 4'b0100);  // R9 clear vs staggered sample
    run_edge(4, 1'b1, 4'hF, 4'b1001);  // R9 clear vs simultaneous release
    run_edge(3, 1'b0, 4'hD, 4'b0010);
    for (int k = 0; k <= N; k++) begin
      run_level(k, 1'b0, 4'hA, 4'h5);
      run_level(k, 1'b1, 4'h7, 4'hC);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule